// File: doc/BRIEF.md
# Fast-Lock Delay-Line Lock Controller

This block is the digital controller of an all-digital delay-locked loop. It brings the delay code of an external delay line to the point where the delayed clock lines up with the input clock one period later, and it does so in a fixed number of cycles. A start request opens the process. The block first drives two pulse controls into a time-to-digital converter and captures the converter's thermometer taps. From that snapshot it derives the coarse field of the delay code. It then resolves the fine field with a binary search, one bit at a time, steered by the UP/DN pair from a phase detector.

Lock is reached exactly thirteen input-clock cycles after the start request is sampled: four for coarse acquisition and nine for the five-bit search. The locked flag and the final code then hold until reset or the next start request. The delay line, the phase detector and the converter cells are outside this block.

Top module: `dll_lock_ctrl`

## Requirements
- R1: After synchronous reset, `lock_code` is 0, and `locked`, `tdc_pulse_start` and `tdc_pulse_end` are all low.
- R2: `tdc_pulse_start` rises on the first clock edge after the edge that samples `start`. `tdc_pulse_end` rises on the second such edge. Both are low again after the fourth edge.
- R3: The coarse field is `lock_code[6:5]`. It equals the number of consecutive ones in `tdc_taps`, counted upward from bit 0 and stopping at the first zero, so that bits beyond a zero are ignored. The value is clamped to 3: an all-zero snapshot gives 0 and an all-ones snapshot gives 3.
- R4: The fine field is `lock_code[4:0]`. It is resolved MSB first. Each bit is first set as a trial. It is cleared if, at its decision edge, `pd_dn` is high and `pd_up` is low; otherwise it is kept. Against a delay line whose DN output is high exactly when the code exceeds a target, the result is the largest fine value that keeps the code at or below the target, or 0 if there is none.
- R5: If `pd_up` and `pd_dn` are both high at a decision edge, the bit under trial is kept.
- R6: `locked` rises 13 clock edges after the edge that samples `start`, on the same edge that registers the final code. It is still low after 12 edges.
- R7: While `locked` is high and `start` is low, `lock_code` does not change and `locked` stays high.
- R8: A start request, whether made mid-search or while locked, drops `locked` on the next edge and runs a complete new lock with the same timing.
- R9: `lock_code` keeps its previous value through the first three edges after the start edge. The new coarse field first appears after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a lock sequence |
| tdc_taps | input | 4 | Thermometer snapshot from the converter's coarse taps; bit 0 is the shortest delay |
| pd_up | input | 1 | Phase detector: delayed clock is early |
| pd_dn | input | 1 | Phase detector: delayed clock is late |
| lock_code | output | 7 | Binary delay code: coarse in [6:5], fine in [4:0] |
| tdc_pulse_start | output | 1 | Converter start pulse |
| tdc_pulse_end | output | 1 | Converter end pulse |
| locked | output | 1 | Lock reached; code is final |

## Verification
Four properties are checked on every cycle: the ordering of the two converter pulses, the exact thirteen-cycle distance from a start request to the rise of `locked` (measured with a counter), the dropping of `locked` after every start request, and the frozen code while locked. Only the directed scenarios can show that the values are right. They cover the coarse value chosen for clamped and bubbled snapshots, the fine value the search settles on against a modelled delay line, the treatment of a conflicting UP/DN pair, and the code held through acquisition after a restart.

// File: rtl/dll_lock_pkg.sv
`timescale 1ns/1ps
package dll_lock_pkg;

  // Fine-search sequencing states
  typedef enum logic [1:0] {
    SRCH_IDLE    = 2'd0,
    SRCH_SETTLE  = 2'd1,
    SRCH_DECIDE  = 2'd2,
    SRCH_HOLD    = 2'd3
  } srch_state_t;

  // Cycles spent on coarse acquisition: start pulse, end pulse, capture, load
  localparam int unsigned ACQ_LEN = 4;

  // Total start-to-lock latency for a given fine width
  function automatic int unsigned lock_latency(input int unsigned fine_bits);
    return ACQ_LEN + 2 * fine_bits - 1;
  endfunction

endpackage

// File: rtl/dll_therm_enc.sv
`timescale 1ns/1ps
// Leading-ones encoder for a thermometer snapshot, clamped to the coarse range.
module dll_therm_enc #(
  parameter int unsigned TAPS = 4,
  parameter int unsigned CW   = $clog2(TAPS)
) (
  input  logic [TAPS-1:0] therm,
  output logic [CW-1:0]   coarse
);
  localparam int unsigned KW  = $clog2(TAPS + 1);
  localparam int unsigned MAX = TAPS - 1;

  // run[i] is high when taps 0..i are all ones
  logic [TAPS-1:0] run;

  assign run[0] = therm[0];
  genvar g;
  generate
    for (g = 1; g < TAPS; g++) begin : g_run
      assign run[g] = run[g-1] & therm[g];
    end
  endgenerate

  logic [KW-1:0] ones;
  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + KW'(run[i]);
    end
  end

  // Clamp: a full thermometer saturates at the top coarse value
  always_comb begin
    if (ones > KW'(MAX)) coarse = CW'(MAX);
    else                 coarse = CW'(ones);
  end

endmodule

// File: rtl/dll_tdc_acq.sv
`timescale 1ns/1ps
// Coarse acquisition sequencer: drives the converter pulses, captures taps,
// and announces the load edge with the encoded coarse value.
module dll_tdc_acq
  import dll_lock_pkg::*;
#(
  parameter int unsigned TAPS = 4,
  parameter int unsigned CW   = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TAPS-1:0] taps,
  output logic            pulse_start,
  output logic            pulse_end,
  output logic            load,
  output logic [CW-1:0]   coarse
);
  localparam int unsigned SW = $clog2(ACQ_LEN);

  logic            active;
  logic [SW-1:0]   step;
  logic [TAPS-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      step        <= '0;
      snap        <= '0;
      pulse_start <= 1'b0;
      pulse_end   <= 1'b0;
    end else if (start) begin
      active      <= 1'b1;
      step        <= '0;
      pulse_start <= 1'b0;
      pulse_end   <= 1'b0;
    end else if (active) begin
      step <= step + SW'(1);
      case (step)
        SW'(0): pulse_start <= 1'b1;
        SW'(1): pulse_end   <= 1'b1;
        SW'(2): snap        <= taps;
        default: begin
          active      <= 1'b0;
          pulse_start <= 1'b0;
          pulse_end   <= 1'b0;
        end
      endcase
    end
  end

  assign load = active && !start && (step == SW'(ACQ_LEN - 1));

  dll_therm_enc #(.TAPS(TAPS), .CW(CW)) u_enc (
    .therm  (snap),
    .coarse (coarse)
  );

endmodule

// File: rtl/dll_fine_search.sv
`timescale 1ns/1ps
// Successive-approximation search over the fine field, MSB first.
module dll_fine_search
  import dll_lock_pkg::*;
#(
  parameter int unsigned CW = 2,
  parameter int unsigned FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          load,
  input  logic [CW-1:0] coarse_in,
  input  logic          up,
  input  logic          dn,
  output logic [CW-1:0] coarse_q,
  output logic [FW-1:0] fine_q,
  output logic          locked
);
  localparam int unsigned IW = (FW > 1) ? $clog2(FW) : 1;

  srch_state_t   state;
  logic [IW-1:0] idx;
  logic          late;
  logic [FW-1:0] fine_nxt;

  // Clear only on an unambiguous "late" decision
  assign late = dn && !up;

  always_comb begin
    fine_nxt = fine_q;
    if (late) fine_nxt[idx] = 1'b0;
    if (idx != '0) fine_nxt[idx - IW'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SRCH_IDLE;
      idx      <= '0;
      coarse_q <= '0;
      fine_q   <= '0;
      locked   <= 1'b0;
    end else if (start) begin
      state  <= SRCH_IDLE;
      locked <= 1'b0;
    end else begin
      case (state)
        SRCH_IDLE: begin
          if (load) begin
            coarse_q <= coarse_in;
            fine_q   <= FW'(1) << (FW - 1);
            idx      <= IW'(FW - 1);
            state    <= (FW == 1) ? SRCH_DECIDE : SRCH_SETTLE;
          end
        end
        SRCH_SETTLE: state <= SRCH_DECIDE;
        SRCH_DECIDE: begin
          fine_q <= fine_nxt;
          if (idx == '0) begin
            state  <= SRCH_HOLD;
            locked <= 1'b1;
          end else begin
            idx   <= idx - IW'(1);
            // the last bit is decided without a settle cycle
            state <= (idx == IW'(1)) ? SRCH_DECIDE : SRCH_SETTLE;
          end
        end
        default: state <= SRCH_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/dll_lock_ctrl.sv
`timescale 1ns/1ps
// Two-phase lock controller: fixed coarse acquisition then bounded search.
module dll_lock_ctrl #(
  parameter int unsigned TDC_TAPS  = 4,
  parameter int unsigned FINE_BITS = 5,
  localparam int unsigned COARSE_W = $clog2(TDC_TAPS),
  localparam int unsigned CODE_W   = COARSE_W + FINE_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [TDC_TAPS-1:0] tdc_taps,
  input  logic                pd_up,
  input  logic                pd_dn,
  output logic [CODE_W-1:0]   lock_code,
  output logic                tdc_pulse_start,
  output logic                tdc_pulse_end,
  output logic                locked
);
  logic                load;
  logic [COARSE_W-1:0] coarse_enc;
  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_BITS-1:0] fine_q;

  dll_tdc_acq #(.TAPS(TDC_TAPS), .CW(COARSE_W)) u_acq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .taps        (tdc_taps),
    .pulse_start (tdc_pulse_start),
    .pulse_end   (tdc_pulse_end),
    .load        (load),
    .coarse      (coarse_enc)
  );

  dll_fine_search #(.CW(COARSE_W), .FW(FINE_BITS)) u_srch (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load      (load),
    .coarse_in (coarse_enc),
    .up        (pd_up),
    .dn        (pd_dn),
    .coarse_q  (coarse_q),
    .fine_q    (fine_q),
    .locked    (locked)
  );

  assign lock_code = {coarse_q, fine_q};

endmodule

// File: rtl/dll_lock_ctrl_chk.sv
`timescale 1ns/1ps
module dll_lock_ctrl_chk #(
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned FINE_BITS = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              tdc_pulse_start,
  input logic              tdc_pulse_end,
  input logic              locked,
  input logic [CODE_W-1:0] lock_code
);
  localparam int unsigned LAT = dll_lock_pkg::lock_latency(FINE_BITS);
  localparam int unsigned CTW = $clog2(LAT + 2);

  logic [CTW-1:0] since_start;
  always_ff @(posedge clk) begin
    if (rst)                        since_start <= '0;
    else if (start)                 since_start <= '0;
    else if (since_start != '1)     since_start <= since_start + CTW'(1);
  end

  AST_END_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    tdc_pulse_end |-> tdc_pulse_start); // R2

  AST_END_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(tdc_pulse_start) && !start) |=> $rose(tdc_pulse_end)); // R2

  AST_LOCK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (since_start == CTW'(LAT))); // R6

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (locked && !start) |=> (locked && $stable(lock_code))); // R7

  AST_START_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    start |=> !locked); // R8

  AST_QUIET_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    locked |-> (!tdc_pulse_start && !tdc_pulse_end)); // R2

endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk #(.CODE_W(CODE_W), .FINE_BITS(FINE_BITS)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .start           (start),
  .tdc_pulse_start (tdc_pulse_start),
  .tdc_pulse_end   (tdc_pulse_end),
  .locked          (locked),
  .lock_code       (lock_code)
);

// File: tb/tb_dll_lock_ctrl.sv
`timescale 1ns/1ps
module tb_dll_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [3:0] taps;
  int         target;
  bit         both;
  logic       pd_up, pd_dn;
  logic [6:0] lock_code;
  logic       ps, pe, locked;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  // Behavioural delay line + phase detector: late when code exceeds target
  assign pd_dn = both ? 1'b1 : (int'(lock_code) > target);
  assign pd_up = both ? 1'b1 : ~pd_dn;

  dll_lock_ctrl dut (
    .clk(clk), .rst(rst), .start(start), .tdc_taps(taps),
    .pd_up(pd_up), .pd_dn(pd_dn), .lock_code(lock_code),
    .tdc_pulse_start(ps), .tdc_pulse_end(pe), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_coarse(input logic [3:0] t);
    int k = 0;
    for (int i = 0; i < 4; i++) begin
      if (t[i] && k == i) k++;
    end
    return (k > 3) ? 3 : k;
  endfunction

  function automatic int exp_fine(input int c, input int t, input bit b);
    int base = c * 32;
    if (b) return 31;
    if (t < base) return 0;
    if (t - base > 31) return 31;
    return t - base;
  endfunction

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; taps = '0; target = 0; both = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 code", int'(lock_code), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 pulses", int'({ps, pe}), 0);
  endtask

  // Full lock sequence with timing and value checks
  task automatic run_lock(input logic [3:0] tp, input int tgt, input bit b, input string tag);
    int c, f, prev;
    taps = tp; target = tgt; both = b;
    c = exp_coarse(tp);
    f = exp_fine(c, tgt, b);
    @(negedge clk);
    prev = int'(lock_code);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk({"R2 start pulse ", tag}, int'({ps, pe}), 2);
        chk({"R8 unlocked ", tag}, int'(locked), 0);
      end
      if (i == 2) chk({"R2 end pulse ", tag}, int'({ps, pe}), 3);
      if (i == 3) chk({"R9 code held ", tag}, int'(lock_code), prev);
      if (i == 4) begin
        chk({"R2 pulses low ", tag}, int'({ps, pe}), 0);
        chk({"R3 coarse ", tag}, int'(lock_code[6:5]), c);
      end
      if (i == 12) chk({"R6 not yet ", tag}, int'(locked), 0);
      if (i == 13) begin
        chk({"R6 locked ", tag}, int'(locked), 1);
        chk({"R4 code ", tag}, int'(lock_code), c * 32 + f);
      end
    end
    target = 0; // perturb the detector: code must not move
    repeat (3) @(negedge clk);
    chk({"R7 hold code ", tag}, int'(lock_code), c * 32 + f);
    chk({"R7 hold lock ", tag}, int'(locked), 1);
    both = 0;
  endtask

  task automatic t_restart_mid();
    taps = 4'b0001; target = 50; both = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 mid-search not locked", int'(locked), 0);
    run_lock(4'b0111, 83, 0, "R8 restart");
  endtask

  initial begin
    t_reset();
    run_lock(4'b0011, 77, 0, "R4 mid");
    run_lock(4'b0000, 20, 0, "R3 zeros");
    run_lock(4'b1111, 127, 0, "R3 ones");
    run_lock(4'b1111, 50, 0, "R4 below");
    run_lock(4'b0101, 40, 0, "R3 bubble");
    run_lock(4'b0010, 10, 1, "R5 both");
    t_restart_mid();
    run_lock(4'b0001, 35, 0, "R8 relock");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule